// File: doc/BRIEF.md
# Two-Tier Reset Source Controller

This block gathers every reset request of the chip and drives two active-low reset outputs, one per tier. The system tier covers the external reset pin, two watchdog timeouts, a software request, and low-power entries that the option inputs have turned into resets. The power tier covers power-on/power-down, brownout and standby-exit events. A power reset always also holds the system tier in reset. Both outputs assert at once, combinationally from the request or from the controller's own reset. They release on a clock edge, and only after a fixed stretch interval with no request active.

An eight-bit sticky cause register records which sources were active. It survives a system reset, so software can read the cause after the chip restarts. A power reset clears it, and then the power cause is written back in, so that cause is still recorded. Software clears all bits at once with a single control input. The block also has two preserve indications: one tells the cause register to hold its state, and one tells the backup domain to hold its state.

Top module: `rst_src_ctrl`

## Requirements
- R1: A high level on `wwdg_to_i`, `iwdg_to_i` or `sw_req_i` drives `sys_rst_no` low in the same cycle, while `pwr_rst_no` stays high.
- R2: `ext_rst_ni` passes through a two-flop synchronizer. A low level drives `sys_rst_no` low after the second rising clock edge that samples it.
- R3: `stby_entry_i` with `stby_opt_i`=0, or `stop_entry_i` with `stop_opt_i`=0, is a system reset request. When the matching option input is 1, the entry has no effect on the outputs or on the flags.
- R4: A high level on `por_i`, `bor_i` or `stby_exit_i` drives both `pwr_rst_no` and `sys_rst_no` low in the same cycle. `sys_rst_no` is never high while `pwr_rst_no` is low.
- R5: Each output is released (goes high) exactly 20 rising edges after the last edge at which a request for its tier was sampled. This holds for `sys_rst_no` with the external pin measured at the synchronizer output.
- R6: Flag bit positions are: 0 external pin, 1 window watchdog, 2 independent watchdog, 3 software, 4 low-power entry, 5 power-on/down, 6 brownout, 7 standby exit. A bit is set at the rising edge that samples its source active, and it stays set.
- R7: A system-only reset leaves all flags in place. `keep_flags_o` is high while `sys_rst_no` is low and `pwr_rst_no` is high.
- R8: At each edge where a power source is active, the flags are cleared and then loaded with the sources active at that edge. After a power reset, the flags hold only the sources that were active at its last edge.
- R9: `flag_clr_i` high at an edge clears all flags, except bits whose source is active at that same edge.
- R10: While `rst_ni` is low, both outputs are low and the flags are 0. After `rst_ni` rises, both outputs are released 20 edges later.
- R11: `bkp_keep_o` is high whenever either reset output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| wwdg_to_i | input | 1 | Window watchdog timeout |
| iwdg_to_i | input | 1 | Independent watchdog timeout |
| sw_req_i | input | 1 | Software reset request |
| stby_entry_i | input | 1 | Standby entry sequence completed |
| stop_entry_i | input | 1 | Stop entry sequence completed |
| stby_opt_i | input | 1 | 0: standby entry causes reset |
| stop_opt_i | input | 1 | 0: stop entry causes reset |
| por_i | input | 1 | Power-on / power-down condition |
| bor_i | input | 1 | Brownout condition |
| stby_exit_i | input | 1 | Exit from standby |
| flag_clr_i | input | 1 | Clear all cause flags |
| sys_rst_no | output | 1 | System reset, active low |
| pwr_rst_no | output | 1 | Power reset, active low |
| keep_flags_o | output | 1 | Cause flags must be preserved |
| bkp_keep_o | output | 1 | Backup domain must be preserved |
| flags_o | output | 8 | Sticky reset cause flags |

## Verification
Direct requests show on the reset outputs in the same cycle, so the bench checks them 1 ns after driving the input at a falling edge. The external pin needs two rising edges before it reaches the outputs, and three before its flag is set. A flag is due at the first rising edge after its source is driven, so flags are read at the next falling edge. Release is checked by counting falling edges after a source drops: the output must still be low at 19 edges and high at 20, or at 21 and 22 for the pin because of the synchronizer. Random source choices and hold lengths are mixed with directed cases for the option inputs, flag clearing and overlapping tiers.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int NUM_SRC = 8;
  localparam int SRC_EXT = 0;
  localparam int SRC_WWD = 1;
  localparam int SRC_IWD = 2;
  localparam int SRC_SW  = 3;
  localparam int SRC_LP  = 4;
  localparam int SRC_POR = 5;
  localparam int SRC_BOR = 6;
  localparam int SRC_SBX = 7;
  localparam int NUM_SYS = 5;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], pin_i};
  end

  assign pin_o = q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int STRETCH = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt_q;

  // reset loads the counter so the output holds for a full interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LOAD;
    else if (req_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rst_flag_reg.sv
module rst_flag_reg
  import rst_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wipe_i,
  input  src_vec_t set_i,
  output src_vec_t flags_o
);
  src_vec_t flags_q;

  // clear first, then record: a wiping source still leaves its own mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (wipe_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_pkg::*;
#(
  parameter int STRETCH     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_rst_ni,
  input  logic                wwdg_to_i,
  input  logic                iwdg_to_i,
  input  logic                sw_req_i,
  input  logic                stby_entry_i,
  input  logic                stop_entry_i,
  input  logic                stby_opt_i,
  input  logic                stop_opt_i,
  input  logic                por_i,
  input  logic                bor_i,
  input  logic                stby_exit_i,
  input  logic                flag_clr_i,
  output logic                sys_rst_no,
  output logic                pwr_rst_no,
  output logic                keep_flags_o,
  output logic                bkp_keep_o,
  output logic [NUM_SRC-1:0]  flags_o
);
  logic     ext_sync;
  logic     lp_req;
  src_vec_t cur_src;
  logic     pwr_now;
  logic     sys_now;
  logic     sys_busy;
  logic     pwr_busy;

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_rst_ni),
    .pin_o  (ext_sync)
  );

  assign lp_req = (stby_entry_i & ~stby_opt_i) | (stop_entry_i & ~stop_opt_i);

  always_comb begin
    cur_src          = '0;
    cur_src[SRC_EXT] = ~ext_sync;
    cur_src[SRC_WWD] = wwdg_to_i;
    cur_src[SRC_IWD] = iwdg_to_i;
    cur_src[SRC_SW]  = sw_req_i;
    cur_src[SRC_LP]  = lp_req;
    cur_src[SRC_POR] = por_i;
    cur_src[SRC_BOR] = bor_i;
    cur_src[SRC_SBX] = stby_exit_i;
  end

  assign pwr_now = |cur_src[NUM_SRC-1:NUM_SYS];
  // power tier always drags the system tier with it
  assign sys_now = |cur_src;

  rst_stretch #(.STRETCH(STRETCH)) u_sys_str (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (sys_now),
    .busy_o (sys_busy)
  );

  rst_stretch #(.STRETCH(STRETCH)) u_pwr_str (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pwr_now),
    .busy_o (pwr_busy)
  );

  rst_flag_reg u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wipe_i  (pwr_now | flag_clr_i),
    .set_i   (cur_src),
    .flags_o (flags_o)
  );

  // async assert from request or counter, sync release via counter
  assign sys_rst_no   = ~(sys_now | sys_busy);
  assign pwr_rst_no   = ~(pwr_now | pwr_busy);
  assign keep_flags_o = ~sys_rst_no & pwr_rst_no;
  assign bkp_keep_o   = ~sys_rst_no | ~pwr_rst_no;
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk
  import rst_pkg::*;
#(
  parameter int STRETCH = 20
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sys_rst_no,
  input logic           pwr_rst_no,
  input logic           wwdg_to_i,
  input logic           iwdg_to_i,
  input logic           sw_req_i,
  input logic           por_i,
  input logic           flag_clr_i,
  input logic           pwr_now,
  input logic           sys_now,
  input src_vec_t       cur_src,
  input logic [NUM_SRC-1:0] flags_o
);
  localparam int DW = $clog2(STRETCH + 1);
  localparam logic [DW-1:0] DMAX = DW'(STRETCH);

  logic [DW-1:0] dist_q;

  // edges since a request was last sampled, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            dist_q <= '0;
    else if (sys_now)       dist_q <= '0;
    else if (dist_q < DMAX) dist_q <= dist_q + 1'b1;
  end

  assert_direct_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwdg_to_i | iwdg_to_i | sw_req_i) |-> !sys_rst_no);

  assert_tier_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_rst_no |-> !sys_rst_no);

  assert_stretch_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (dist_q >= DMAX));

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_now | flag_clr_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_por_recorded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> flags_o[SRC_POR]);

  assert_clear_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && cur_src == '0) |=> (flags_o == '0));
endmodule

bind rst_src_ctrl rst_src_ctrl_chk #(.STRETCH(STRETCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_rst_no (sys_rst_no),
  .pwr_rst_no (pwr_rst_no),
  .wwdg_to_i  (wwdg_to_i),
  .iwdg_to_i  (iwdg_to_i),
  .sw_req_i   (sw_req_i),
  .por_i      (por_i),
  .flag_clr_i (flag_clr_i),
  .pwr_now    (pwr_now),
  .sys_now    (sys_now),
  .cur_src    (cur_src),
  .flags_o    (flags_o)
);

// File: tb/rst_src_ctrl_bench.sv
module rst_src_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STR = 20;

  logic clk = 1'b0;
  logic rst_n, ext_n, wwdg, iwdg, swr, stby_en, stop_en, stby_opt, stop_opt;
  logic por, bor, sbx, fclr;
  logic sys_n, pwr_n, keep_f, keep_b;
  logic [7:0] flags;
  logic [7:0] exp_flags;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_src_ctrl u_rst_src_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_n), .wwdg_to_i(wwdg),
    .iwdg_to_i(iwdg), .sw_req_i(swr), .stby_entry_i(stby_en),
    .stop_entry_i(stop_en), .stby_opt_i(stby_opt), .stop_opt_i(stop_opt),
    .por_i(por), .bor_i(bor), .stby_exit_i(sbx), .flag_clr_i(fclr),
    .sys_rst_no(sys_n), .pwr_rst_no(pwr_n), .keep_flags_o(keep_f),
    .bkp_keep_o(keep_b), .flags_o(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_src(input int idx, input logic v);
    case (idx)
      0: ext_n   = ~v;
      1: wwdg    = v;
      2: iwdg    = v;
      3: swr     = v;
      4: stby_en = v;
      5: por     = v;
      6: bor     = v;
      default: sbx = v;
    endcase
  endtask

  function automatic logic [7:0] flag_upd(input logic [7:0] f, input int idx);
    if (idx >= 5) return 8'(1 << idx);
    return f | 8'(1 << idx);
  endfunction

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive one source, hold, drop, then time the release
  task automatic pulse(input int idx, input int len);
    int rel;
    @(negedge clk);
    stby_opt = 1'b0;
    set_src(idx, 1'b1);
    #1;
    if (idx != 0) begin
      chk(idx >= 5 ? "R4 sys asserted" : "R1 sys asserted", sys_n, 0);
      chk(idx >= 5 ? "R4 pwr asserted" : "R1 pwr quiet", pwr_n, idx >= 5 ? 0 : 1);
    end
    wait_neg(len);
    exp_flags = flag_upd(exp_flags, idx);
    chk(idx == 0 ? "R2 pin reset" : "R3 held", sys_n, 0);
    chk(idx >= 5 ? "R8 power flags" : "R6 flags", flags, exp_flags);
    chk("R7 keep flags", keep_f, idx < 5 ? 1 : 0);
    chk("R11 backup keep", keep_b, 1);
    set_src(idx, 1'b0);
    stby_opt = 1'b1;
    rel = (idx == 0) ? STR + 2 : STR;
    wait_neg(rel - 1);
    chk("R5 still held", sys_n, 0);
    wait_neg(1);
    chk("R5 released", sys_n, 1);
    chk("R5 pwr released", pwr_n, 1);
    chk("R7 flags kept", flags, exp_flags);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    rst_n = 0; ext_n = 1; wwdg = 0; iwdg = 0; swr = 0; stby_en = 0; stop_en = 0;
    stby_opt = 1; stop_opt = 1; por = 0; bor = 0; sbx = 0; fclr = 0;
    exp_flags = '0;
    wait_neg(3);
    chk("R10 sys in reset", sys_n, 0);
    chk("R10 pwr in reset", pwr_n, 0);
    chk("R10 flags zero", flags, 0);
    rst_n = 1;
    wait_neg(STR - 1);
    chk("R10 held after release", sys_n, 0);
    wait_neg(1);
    chk("R10 sys released", sys_n, 1);
    chk("R10 pwr released", pwr_n, 1);
    chk("R11 backup idle", keep_b, 0);

    // external pin: synchronizer latency
    @(negedge clk); ext_n = 0;
    wait_neg(1);
    chk("R2 one edge quiet", sys_n, 1);
    wait_neg(1);
    chk("R2 two edges asserted", sys_n, 0);
    wait_neg(1);
    exp_flags = 8'h01;
    chk("R6 pin flag", flags, exp_flags);
    ext_n = 1;
    wait_neg(STR + 2);
    chk("R5 pin release", sys_n, 1);

    // low-power entries with option set: no effect
    @(negedge clk); stby_en = 1; stop_en = 1;
    #1 chk("R3 option masks entry", sys_n, 1);
    wait_neg(1);
    chk("R3 no flag", flags, exp_flags);
    stby_en = 0; stop_en = 0;
    // stop entry with option clear
    stop_opt = 0; stop_en = 1;
    #1 chk("R3 stop reset", sys_n, 0);
    wait_neg(1);
    stop_en = 0; stop_opt = 1;
    exp_flags = exp_flags | 8'h10;
    chk("R3 stop flag", flags, exp_flags);
    wait_neg(STR);
    chk("R5 stop release", sys_n, 1);

    // clear all flags
    fclr = 1; wait_neg(1); fclr = 0;
    exp_flags = '0;
    chk("R9 clear", flags, 0);
    // clear while a source is active
    fclr = 1; wwdg = 1; wait_neg(1); fclr = 0; wwdg = 0;
    exp_flags = 8'h02;
    chk("R9 source wins", flags, exp_flags);
    wait_neg(STR);

    // overlap: brownout outlasts software request
    bor = 1; swr = 1;
    wait_neg(2);
    chk("R8 both recorded", flags, 8'h48);
    swr = 0;
    wait_neg(2);
    chk("R8 only last cause", flags, 8'h40);
    exp_flags = 8'h40;
    bor = 0;
    wait_neg(STR - 1);
    chk("R4 pwr still held", pwr_n, 0);
    chk("R4 sys still held", sys_n, 0);
    wait_neg(1);
    chk("R4 pwr release", pwr_n, 1);
    chk("R4 sys release", sys_n, 1);

    for (int k = 0; k < 30; k++) begin
      pulse(int'($urandom % 8), 3 + int'($urandom % 4));
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule